// File: doc/BRIEF.md
# Dual-Strobe Decade Up/Down Counter

This block holds one BCD digit (0 to 9) and changes it in response to two separate count strobes. A rising edge on the up strobe adds one and a rising edge on the down strobe subtracts one. The count wraps between 9 and 0 in both directions. A clear input and an active-low load input act on the count output at once, within the same cycle, with no clock edge needed. They behave as asynchronous controls would, while the stored count itself stays synchronous to a fast system clock.

Both strobes are synchronised to the system clock through a short flop chain, and their rising edges are found on the synchronised values. There are two active-low terminal outputs, one for the top of the range and one for the bottom. Each goes low only while its own strobe is low and the digit sits at that end of the range, so each one repeats its strobe's waveform and can serve as the strobe of a following digit.

The lowest count bit can only flip while both strobes are high. Holding the idle strobe low therefore gives a defined step of two, or no step at all, depending on the lowest bit. The block also has a defined way out of loaded values from 10 to 15.

Top module: `bcd_updown_ctr`

## Requirements
- R1: While `clr` is high, `q` reads 0 in the same cycle, whatever `load_n` and the strobes do. The stored count is 0 once `clr` falls.
- R2: While `clr` is low and `load_n` is low, `q` equals `pdata` in the same cycle, for any value 0 to 15. After `load_n` rises, the value stays.
- R3: With `clr` low, `load_n` high and no strobe rising edge, the count holds.
- R4: A rising edge on `up_stb` while `dn_stb` is high adds one, and 9 goes to 0. The new count appears after the third rising clock edge that follows the strobe change.
- R5: A rising edge on `dn_stb` while `up_stb` is high subtracts one, and 0 goes to 9. The timing is the same as in R4.
- R6: `carry_n` is low only when `q[0]` and `q[3]` are both 1 and the synchronised up strobe is low. This low level shows two clock edges after `up_stb` falls.
- R7: `borrow_n` is low only when `q` is 0 and the synchronised down strobe is low. The delay is the same as in R6.
- R8: A strobe held low through a clear or a load, and still low afterwards, counts on its next rising edge.
- R9: An up edge while `dn_stb` is low adds two when `q[0]` is 1 and does nothing when it is 0. A down edge while `up_stb` is low subtracts two when `q[0]` is 0 and does nothing when it is 1.
- R10: Rising edges on both strobes in the same cycle leave the count unchanged.
- R11: From a loaded value of 10 to 15, counting up gives the next binary value, except that 15 goes to 0. Counting down gives the previous binary value.
- R12: The synchronous system reset `rst` sets the count to 0 and treats both strobes as high, so leaving reset creates no count event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| clr | input | 1 | Digit clear, active high, acts on `q` at once |
| load_n | input | 1 | Preset enable, active low, acts on `q` at once |
| pdata | input | 4 | Preset value |
| up_stb | input | 1 | Count-up strobe, counts on its rising edge |
| dn_stb | input | 1 | Count-down strobe, counts on its rising edge |
| q | output | 4 | Current digit |
| carry_n | output | 1 | Top-of-range terminal output, active low |
| borrow_n | output | 1 | Bottom-of-range terminal output, active low |

## Verification
Single pulses on one strobe, with the other strobe held high, walk the count through both wraps. Those walks tell apart correct wrapping, an off-by-one step and a wrong direction. Loads of values from 10 to 15 followed by pulses check the defined exit from those codes. Pulses with the idle strobe held low, once with an odd start value and once with an even one, separate the step of two from the stall. A simultaneous rise on both strobes and a strobe held low through a clear show whether edges are ignored or kept as the rules require. Holding each strobe low at the matching end of the range shows whether the terminal outputs follow the strobe level or only the count.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

    localparam int unsigned DIGIT_W = 4;
    localparam int unsigned N_STROBES = 2;
    localparam int unsigned UP_IDX = 0;
    localparam int unsigned DN_IDX = 1;

    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t DIGIT_MAX = digit_t'(9);
    localparam digit_t CODE_MAX = '1;

    // synchronised view of one count strobe
    typedef struct packed {
        logic lvl;
        logic rise;
    } strobe_t;

    function automatic digit_t digit_inc(digit_t d);
        if (d == DIGIT_MAX || d == CODE_MAX)
            return '0;
        return d + digit_t'(1);
    endfunction

    function automatic digit_t digit_dec(digit_t d);
        if (d == '0)
            return DIGIT_MAX;
        return d - digit_t'(1);
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import bcd_ctr_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    raw,
    output strobe_t st
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // reset to all ones: an idle-high strobe gives no edge after reset
    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[CHAIN_W-2:0], raw};
    end

    always_comb begin
        st.lvl  = chain[STAGES-1];
        st.rise = chain[STAGES-1] & ~chain[STAGES];
    end

endmodule

// File: rtl/bcd_step.sv
module bcd_step
    import bcd_ctr_pkg::*;
(
    input  digit_t  cur,
    input  strobe_t up,
    input  strobe_t dn,
    output digit_t  nxt
);
    // the lowest bit only flips while both strobe levels are high
    always_comb begin
        nxt = cur;
        if (up.rise && !dn.rise) begin
            if (dn.lvl)
                nxt = digit_inc(cur);
            else if (cur[0])
                nxt = digit_inc(digit_inc(cur));
        end else if (dn.rise && !up.rise) begin
            if (up.lvl)
                nxt = digit_dec(cur);
            else if (!cur[0])
                nxt = digit_dec(digit_dec(cur));
        end
    end

endmodule

// File: rtl/tc_gen.sv
module tc_gen
    import bcd_ctr_pkg::*;
(
    input  digit_t q,
    input  logic   up_lvl,
    input  logic   dn_lvl,
    output logic   carry_n,
    output logic   borrow_n
);
    always_comb begin
        carry_n  = ~(q[0] & q[DIGIT_W-1] & ~up_lvl);
        borrow_n = ~((q == '0) & ~dn_lvl);
    end

endmodule

// File: rtl/bcd_updown_ctr.sv
module bcd_updown_ctr
    import bcd_ctr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load_n,
    input  logic [3:0] pdata,
    input  logic       up_stb,
    input  logic       dn_stb,
    output logic [3:0] q,
    output logic       carry_n,
    output logic       borrow_n
);
    logic [N_STROBES-1:0] raw_stb;
    strobe_t              st [N_STROBES];
    logic                 up_rise, dn_rise, up_lvl, dn_lvl;
    digit_t               cnt, cnt_nxt, q_int;

    assign raw_stb[UP_IDX] = up_stb;
    assign raw_stb[DN_IDX] = dn_stb;

    for (genvar i = 0; i < N_STROBES; i++) begin : g_sync
        strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .raw (raw_stb[i]),
            .st  (st[i])
        );
    end

    assign up_rise = st[UP_IDX].rise;
    assign dn_rise = st[DN_IDX].rise;
    assign up_lvl  = st[UP_IDX].lvl;
    assign dn_lvl  = st[DN_IDX].lvl;

    bcd_step u_step (
        .cur (cnt),
        .up  (st[UP_IDX]),
        .dn  (st[DN_IDX]),
        .nxt (cnt_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (!load_n)
            cnt <= pdata;
        else
            cnt <= cnt_nxt;
    end

    // clear and load reach the output within the cycle
    always_comb begin
        if (clr)
            q_int = '0;
        else if (!load_n)
            q_int = pdata;
        else
            q_int = cnt;
    end

    assign q = q_int;

    tc_gen u_tc (
        .q        (q_int),
        .up_lvl   (up_lvl),
        .dn_lvl   (dn_lvl),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

endmodule

// File: rtl/bcd_updown_ctr_chk.sv
module bcd_updown_ctr_chk (
    input logic       clk,
    input logic       rst,
    input logic       clr,
    input logic       load_n,
    input logic [3:0] pdata,
    input logic       up_stb,
    input logic       dn_stb,
    input logic [3:0] q,
    input logic       carry_n,
    input logic       borrow_n,
    input logic       up_rise,
    input logic       dn_rise,
    input logic       up_lvl,
    input logic       dn_lvl
);
    assert_clr_zero_R1: assert property (@(posedge clk) disable iff (rst)
        clr |-> (q == 4'd0));

    assert_load_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_n) |-> (q == pdata));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && !up_rise && !dn_rise) |=> (clr || !load_n || q == $past(q)));

    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && up_rise && !dn_rise && dn_lvl && q == 4'd9)
            |=> (clr || !load_n || q == 4'd0));

    assert_dn_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && dn_rise && !up_rise && up_lvl && q == 4'd0)
            |=> (clr || !load_n || q == 4'd9));

    assert_carry_cause_R6: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> (!$past(up_stb, 2) && q[0] && q[3]));

    assert_borrow_cause_R7: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> (!$past(dn_stb, 2) && q == 4'd0));

    assert_both_edges_R10: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && up_rise && dn_rise) |=> (clr || !load_n || q == $past(q)));

endmodule

bind bcd_updown_ctr bcd_updown_ctr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load_n   (load_n),
    .pdata    (pdata),
    .up_stb   (up_stb),
    .dn_stb   (dn_stb),
    .q        (q),
    .carry_n  (carry_n),
    .borrow_n (borrow_n),
    .up_rise  (up_rise),
    .dn_rise  (dn_rise),
    .up_lvl   (up_lvl),
    .dn_lvl   (dn_lvl)
);

// File: tb/tb_bcd_updown_ctr.sv
module tb_bcd_updown_ctr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] pdata = 4'd0;
    logic       up_stb = 1'b1;
    logic       dn_stb = 1'b1;
    logic [3:0] q;
    logic       carry_n, borrow_n;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bcd_updown_ctr dut (
        .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .pdata(pdata),
        .up_stb(up_stb), .dn_stb(dn_stb), .q(q),
        .carry_n(carry_n), .borrow_n(borrow_n)
    );

    // vector: {op[1:0], data[3:0], expected q[3:0]}; op 0 up, 1 down, 2 load
    localparam int NVEC = 18;
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd2, 4'd7,  4'd7},  {2'd0, 4'd0, 4'd8},  {2'd0, 4'd0, 4'd9},
        {2'd0, 4'd0,  4'd0},  {2'd1, 4'd0, 4'd9},  {2'd1, 4'd0, 4'd8},
        {2'd2, 4'd0,  4'd0},  {2'd1, 4'd0, 4'd9},  {2'd2, 4'd12, 4'd12},
        {2'd0, 4'd0,  4'd13}, {2'd0, 4'd0, 4'd14}, {2'd0, 4'd0, 4'd15},
        {2'd0, 4'd0,  4'd0},  {2'd2, 4'd11, 4'd11}, {2'd1, 4'd0, 4'd10},
        {2'd1, 4'd0,  4'd9},  {2'd2, 4'd10, 4'd10}, {2'd0, 4'd0, 4'd11}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up();
        up_stb = 1'b0; wait_n(3);
        up_stb = 1'b1; wait_n(4);
    endtask

    task automatic pulse_dn();
        dn_stb = 1'b0; wait_n(3);
        dn_stb = 1'b1; wait_n(4);
    endtask

    task automatic do_load(input logic [3:0] d);
        pdata = d; load_n = 1'b0;
        #1 chk("R2 load immediate", q, d);
        wait_n(2);
        load_n = 1'b1;
        wait_n(1);
        chk("R2 load held", q, d);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin : main
        logic [3:0] prev;
        wait_n(3);
        rst = 1'b0;
        wait_n(2);
        chk("R12 reset q", q, 4'd0);
        chk("R12 reset carry_n", {3'b0, carry_n}, 4'd1);
        chk("R12 reset borrow_n", {3'b0, borrow_n}, 4'd1);

        prev = 4'd0;
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [3:0] dat, exp;
            string tag;
            {op, dat, exp} = VEC[i];
            case (op)
                2'd0: pulse_up();
                2'd1: pulse_dn();
                default: do_load(dat);
            endcase
            if (prev > 4'd9 || exp > 4'd9) tag = "R11 illegal code step";
            else if (op == 2'd0) tag = "R4 count up";
            else if (op == 2'd1) tag = "R5 count down";
            else tag = "R2 load";
            chk(tag, q, exp);
            prev = exp;
        end

        // R1: clear beats load
        pdata = 4'd5; load_n = 1'b0; clr = 1'b1;
        #1 chk("R1 clear over load", q, 4'd0);
        wait_n(2);
        clr = 1'b0;
        #1 chk("R2 load after clear", q, 4'd5);
        wait_n(2);
        load_n = 1'b1;
        // R3: idle strobes hold
        wait_n(10);
        chk("R3 hold", q, 4'd5);

        // R6: carry follows up strobe level at 9
        do_load(4'd9);
        up_stb = 1'b0; wait_n(3);
        chk("R6 carry low at 9", {3'b0, carry_n}, 4'd0);
        chk("R7 borrow idle", {3'b0, borrow_n}, 4'd1);
        up_stb = 1'b1; wait_n(4);
        chk("R4 wrap 9 to 0", q, 4'd0);
        chk("R6 carry high", {3'b0, carry_n}, 4'd1);

        // R7: borrow follows down strobe level at 0
        dn_stb = 1'b0; wait_n(3);
        chk("R7 borrow low at 0", {3'b0, borrow_n}, 4'd0);
        chk("R6 carry idle", {3'b0, carry_n}, 4'd1);
        dn_stb = 1'b1; wait_n(4);
        chk("R5 wrap 0 to 9", q, 4'd9);
        chk("R7 borrow high", {3'b0, borrow_n}, 4'd1);

        // R8: strobe low through clear, then counted
        up_stb = 1'b0; wait_n(3);
        clr = 1'b1; wait_n(2);
        clr = 1'b0; wait_n(2);
        chk("R8 cleared", q, 4'd0);
        up_stb = 1'b1; wait_n(4);
        chk("R8 edge after clear", q, 4'd1);
        up_stb = 1'b0; wait_n(3);
        do_load(4'd6);
        up_stb = 1'b1; wait_n(4);
        chk("R8 edge after load", q, 4'd7);

        // R9: idle strobe held low
        dn_stb = 1'b0; wait_n(3);
        do_load(4'd3);
        pulse_up();
        chk("R9 up by two", q, 4'd5);
        do_load(4'd4);
        pulse_up();
        chk("R9 up stall", q, 4'd4);
        dn_stb = 1'b1; wait_n(4);
        chk("R5 down on release", q, 4'd3);
        up_stb = 1'b0; wait_n(3);
        do_load(4'd6);
        pulse_dn();
        chk("R9 down by two", q, 4'd4);
        do_load(4'd5);
        pulse_dn();
        chk("R9 down stall", q, 4'd5);
        up_stb = 1'b1; wait_n(4);
        chk("R4 up on release", q, 4'd6);

        // R10: both rise together
        up_stb = 1'b0; dn_stb = 1'b0; wait_n(3);
        up_stb = 1'b1; dn_stb = 1'b1; wait_n(4);
        chk("R10 both edges", q, 4'd6);

        // R12: system reset
        rst = 1'b1; wait_n(2);
        rst = 1'b0; wait_n(4);
        chk("R12 reset again", q, 4'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule